// File: doc/BRIEF.md
# Serial Register Access Port

This block gives an external host read and write access to a small bank of 8-bit and 16-bit configuration and result registers over a four-wire serial link: active-low select, serial clock, data in and data out. The serial pins are brought into the `clk_i` domain through synchronizers, and the clock edges are found by oversampling. For this to work, each high and low phase of the serial clock must last at least four `clk_i` periods.

A frame does not have to line up with the falling edge of select. Zeros on the data line are skipped, and the first one sampled on a rising serial clock edge is the start bit of a command byte. The rest of that byte gives the transfer direction and a 5-bit register number. The block then moves exactly as many data bits as that register is wide, most significant bit first, and goes back to hunting for the next start bit.

The registers themselves live outside the block, behind a parallel port:
- an address;
- a one-cycle read strobe with combinational read data;
- a one-cycle write strobe with write data.

An end-of-conversion flag from the conversion logic is passed straight through to an output pin.

Top module: `spi_regif`

## Requirements
- R1: While `cs_ni` is high, `dout_en_o` is 0 and toggling `sclk_i` or `din_i` causes no register access and does not start a frame. While `cs_ni` is low, `dout_en_o` is 1.
- R2: Zeros sampled on `din_i` before a frame are skipped. The first 1 sampled at a rising `sclk_i` edge is the start bit, and any number of leading zeros may come before it.
- R3: The command byte is sent MSB first. Its bits are, in order: the start bit (1), a direction bit (1 = read, 0 = write), the register number from bit 4 down to bit 0, and one don't-care bit.
- R4: After the command byte the block moves exactly 16 or 8 data bits, according to the register width in R11. It then hunts for a new start bit, so several frames can follow one another under a single select.
- R5: A write to a writable register gives exactly one `reg_we_o` pulse, and only after the last data bit has been sampled. `reg_wdata_o` carries the received value right-justified, with the upper byte zero for 8-bit registers.
- R6: A write to a read-only register or to an unused number (12 to 31) produces no `reg_we_o` pulse.
- R7: A read gives one `reg_rd_o` pulse after the command byte. The register value is shifted out MSB first on `dout_o`. Each bit is updated at a falling `sclk_i` edge, and the first data bit is valid at the falling edge that follows the last command bit. An 8-bit register sends `reg_rdata_i[7:0]`.
- R8: A read of a write-only register or of an unused number shifts out all zeros, whatever `reg_rdata_i` holds.
- R9: If `cs_ni` rises in the middle of a frame (in the command byte or in the data bits), the partial frame is discarded with no write. The next frame is decoded from a fresh start bit.
- R10: `eoc_o` follows `eoc_i` combinationally.
- R11: The register map gives each register number an access code (RO, WO or RW) and a width:

  | Register | Access | Width |
  |---|---|---|
  | 0 | RO | 8 |
  | 1 | RW | 8 |
  | 2 | RW | 16 |
  | 3 | RW | 16 |
  | 4 | RW | 16 |
  | 5 | WO | 8 |
  | 6 | WO | 16 |
  | 7 | RO | 16 |
  | 8 | RO | 16 |
  | 9 | RW | 8 |
  | 10 | RO | 8 |
  | 11 | RW | 16 |
  | 12 to 31 | unused | 8 |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, at least 8x the serial clock rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock |
| din_i | input | 1 | Serial data from the host |
| dout_o | output | 1 | Serial data to the host |
| dout_en_o | output | 1 | Output enable for `dout_o` (0 = high impedance) |
| eoc_i | input | 1 | End-of-conversion flag from the conversion logic |
| eoc_o | output | 1 | End-of-conversion pin |
| reg_addr_o | output | 5 | Register number for the parallel port |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 16 | Read data, valid in the cycle of `reg_rd_o` |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 16 | Write data, right-justified |

## Verification
The assertions check the following on every cycle:
- a write strobe lasts one cycle and only ever targets a writable register;
- a read strobe happens only inside the data phase of a read;
- an inactive select returns the decoder to hunting with no write pending;
- the data bit counter never runs past the selected width.

Only the bench scenarios can show that the serial bit order and the register decode are right. These scenarios are:
- start-bit detection after varying runs of leading zeros;
- values read back after writes;
- zero reads from unused and write-only registers;
- frames aborted in the command byte and in the data bits;
- frames sent back to back under one select.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

  typedef enum logic [1:0] {ST_HUNT, ST_CMD, ST_DATA} frame_st_e;
  typedef enum logic [1:0] {ACC_NONE, ACC_RO, ACC_WO, ACC_RW} acc_e;

  typedef struct packed {
    acc_e acc;
    logic wide;
  } reg_attr_t;

  function automatic reg_attr_t reg_attr(input logic [4:0] num);
    reg_attr_t a;
    case (num)
      5'd0:    a = '{ACC_RO, 1'b0};
      5'd1:    a = '{ACC_RW, 1'b0};
      5'd2:    a = '{ACC_RW, 1'b1};
      5'd3:    a = '{ACC_RW, 1'b1};
      5'd4:    a = '{ACC_RW, 1'b1};
      5'd5:    a = '{ACC_WO, 1'b0};
      5'd6:    a = '{ACC_WO, 1'b1};
      5'd7:    a = '{ACC_RO, 1'b1};
      5'd8:    a = '{ACC_RO, 1'b1};
      5'd9:    a = '{ACC_RW, 1'b0};
      5'd10:   a = '{ACC_RO, 1'b0};
      5'd11:   a = '{ACC_RW, 1'b1};
      default: a = '{ACC_NONE, 1'b0};
    endcase
    return a;
  endfunction

  function automatic logic can_write(input acc_e a);
    return (a == ACC_WO) || (a == ACC_RW);
  endfunction

  function automatic logic can_read(input acc_e a);
    return (a == ACC_RO) || (a == ACC_RW);
  endfunction

endpackage

// File: rtl/spi_regif_sync.sv
module spi_regif_sync #(
  parameter int unsigned     W       = 3,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/spi_regif_frame.sv
module spi_regif_frame
  import spi_regif_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NARROW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              reg_we_o,
  output logic [DATA_W-1:0] reg_wdata_o
);

  localparam int unsigned CNT_W   = $clog2(DATA_W);
  localparam int unsigned CMD_W   = ADDR_W + 1;
  localparam int unsigned CMD_END = CMD_W;

  frame_st_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CMD_W-1:0]  cmd_q;
  logic              rd_q, wide_q, load_q, we_q, dout_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rx_q, tx_q, wdata_q;
  logic [CNT_W-1:0]  last_bit;
  acc_e              acc;

  assign last_bit = wide_q ? CNT_W'(DATA_W-1) : CNT_W'(NARROW_W-1);
  assign acc      = reg_attr(addr_q).acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_HUNT;
      cnt_q   <= '0;
      cmd_q   <= '0;
      rd_q    <= 1'b0;
      wide_q  <= 1'b0;
      load_q  <= 1'b0;
      we_q    <= 1'b0;
      dout_q  <= 1'b0;
      addr_q  <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      wdata_q <= '0;
    end else begin
      we_q   <= 1'b0;
      load_q <= 1'b0;
      if (load_q) begin
        if (!can_read(acc))  tx_q <= '0;
        else if (wide_q)     tx_q <= reg_rdata_i;
        else                 tx_q <= {reg_rdata_i[NARROW_W-1:0], {(DATA_W-NARROW_W){1'b0}}};
      end
      if (!cs_act_i) begin
        st_q  <= ST_HUNT;
        cnt_q <= '0;
      end else begin
        if (rise_i) begin
          unique case (st_q)
            ST_HUNT: if (din_i) begin
              st_q  <= ST_CMD;
              cnt_q <= '0;
            end
            ST_CMD: begin
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == CNT_W'(CMD_END)) begin
                // din_i here is the don't-care bit
                rd_q   <= cmd_q[CMD_W-1];
                addr_q <= cmd_q[ADDR_W-1:0];
                wide_q <= reg_attr(cmd_q[ADDR_W-1:0]).wide;
                load_q <= cmd_q[CMD_W-1];
                rx_q   <= '0;
                cnt_q  <= '0;
                st_q   <= ST_DATA;
              end else begin
                cmd_q <= {cmd_q[CMD_W-2:0], din_i};
              end
            end
            ST_DATA: begin
              rx_q  <= {rx_q[DATA_W-2:0], din_i};
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == last_bit) begin
                st_q  <= ST_HUNT;
                cnt_q <= '0;
                if (!rd_q && can_write(acc)) begin
                  we_q    <= 1'b1;
                  wdata_q <= {rx_q[DATA_W-2:0], din_i};
                end
              end
            end
            default: st_q <= ST_HUNT;
          endcase
        end
        if (fall_i && st_q == ST_DATA && rd_q) begin
          dout_q <= tx_q[DATA_W-1];
          tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign dout_o      = dout_q;
  assign reg_addr_o  = addr_q;
  assign reg_rd_o    = load_q;
  assign reg_we_o    = we_q;
  assign reg_wdata_o = wdata_q;

  p_we_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> !we_q);
  p_we_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> can_write(reg_attr(addr_q).acc));
  p_rd_phase_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |-> (st_q == ST_DATA) && rd_q);
  p_cs_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> (st_q == ST_HUNT) && !we_q);
  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA) |-> (cnt_q <= last_bit));

endmodule

// File: rtl/spi_regif.sv
module spi_regif
  import spi_regif_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned NARROW_W    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              dout_en_o,
  input  logic              eoc_i,
  output logic              eoc_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              reg_we_o,
  output logic [DATA_W-1:0] reg_wdata_o
);

  logic [2:0] pins_s;
  logic       sclk_d, rise, fall;

  // bit 2: cs (idle high), bit 1: sclk, bit 0: din
  spi_regif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, din_i}),
    .q_o   (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= pins_s[1];
  end

  assign rise = pins_s[1] & ~sclk_d;
  assign fall = ~pins_s[1] & sclk_d;

  spi_regif_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (~pins_s[2]),
    .rise_i     (rise),
    .fall_i     (fall),
    .din_i      (pins_s[0]),
    .dout_o     (dout_o),
    .reg_addr_o (reg_addr_o),
    .reg_rd_o   (reg_rd_o),
    .reg_rdata_i(reg_rdata_i),
    .reg_we_o   (reg_we_o),
    .reg_wdata_o(reg_wdata_o)
  );

  assign dout_en_o = ~cs_ni;
  assign eoc_o     = eoc_i;

  p_edge_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins_s[2] |-> !reg_rd_o || !$rose(reg_rd_o));

endmodule

// File: tb/spi_regif_bench.sv
module spi_regif_bench;

  localparam int HALF = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b0, din = 1'b0, eoc = 1'b0;
  logic        dout, dout_en, eoc_o, rd, we;
  logic [4:0]  addr;
  logic [15:0] rdata, wdata;
  logic [15:0] bank [12];
  logic [15:0] expv [12];
  int          checks = 0, errors = 0, we_cnt = 0, rd_cnt = 0;

  always #2.5 clk = ~clk;

  spi_regif u_spi_regif (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .din_i(din),
    .dout_o(dout), .dout_en_o(dout_en), .eoc_i(eoc), .eoc_o(eoc_o),
    .reg_addr_o(addr), .reg_rd_o(rd), .reg_rdata_i(rdata),
    .reg_we_o(we), .reg_wdata_o(wdata)
  );

  assign rdata = (addr < 5'd12) ? bank[addr] : 16'hDEAD;

  always @(posedge clk) begin
    if (we) begin
      we_cnt <= we_cnt + 1;
      if (addr < 5'd12) bank[addr] <= wdata;
    end
    if (rd) rd_cnt <= rd_cnt + 1;
  end

  // access codes from R11: 0 unused, 1 RO, 2 WO, 3 RW
  function automatic int acc_of(input int a);
    case (a)
      0, 7, 8, 10:    return 1;
      5, 6:           return 2;
      1, 2, 3, 4, 9, 11: return 3;
      default:        return 0;
    endcase
  endfunction

  function automatic int wid_of(input int a);
    return (a == 2 || a == 3 || a == 4 || a == 6 || a == 7 || a == 8 || a == 11) ? 16 : 8;
  endfunction

  function automatic logic [15:0] mask_of(input int a);
    return (wid_of(a) == 16) ? 16'hFFFF : 16'h00FF;
  endfunction

  function automatic logic [15:0] exp_read(input int a);
    if (acc_of(a) == 1 || acc_of(a) == 3) return expv[a] & mask_of(a);
    return 16'h0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] ex);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, ex);
    end
  endtask

  task automatic send_bit(input logic b, output logic s);
    @(negedge clk) din = b;
    repeat (HALF) @(negedge clk);
    s = dout;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic cs_on();
    @(negedge clk) cs_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    din = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // limit: number of data bits sent before stopping (-1 = all)
  task automatic frame(input int lead, input logic r, input int a,
                       input logic [15:0] wd, input int limit, output logic [15:0] got);
    logic s;
    int n;
    logic [4:0] a5;
    n = wid_of(a);
    a5 = 5'(a);
    got = '0;
    for (int i = 0; i < lead; i++) send_bit(1'b0, s);
    send_bit(1'b1, s);
    send_bit(r, s);
    for (int i = 4; i >= 0; i--) send_bit(a5[i], s);
    send_bit(1'($urandom), s);
    for (int i = n - 1; i >= 0; i--) begin
      if (limit >= 0 && (n - 1 - i) >= limit) return;
      send_bit(wd[i], s);
      got = {got[14:0], s};
    end
  endtask

  task automatic do_write(input int a, input logic [15:0] d, input int lead);
    logic [15:0] g;
    int w0;
    w0 = we_cnt;
    cs_on();
    frame(lead, 1'b0, a, d, -1, g);
    cs_off();
    if (acc_of(a) >= 2) begin
      expv[a] = d & mask_of(a);
      check(we_cnt == w0 + 1, "R5", "write strobe count", 16'(we_cnt - w0), 16'd1);
      check(bank[a] == expv[a], "R5", "written value", bank[a], expv[a]);
    end else begin
      check(we_cnt == w0, "R6", "ignored write strobe", 16'(we_cnt - w0), 16'd0);
      if (a < 12) check(bank[a] == expv[a], "R6", "ro reg unchanged", bank[a], expv[a]);
    end
  endtask

  task automatic do_read(input int a, input int lead, input string req);
    logic [15:0] g;
    int r0;
    r0 = rd_cnt;
    cs_on();
    frame(lead, 1'b1, a, 16'h0, -1, g);
    cs_off();
    check(rd_cnt == r0 + 1, "R7", "read strobe count", 16'(rd_cnt - r0), 16'd1);
    check(g == exp_read(a), req, $sformatf("read reg %0d", a), g, exp_read(a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] g;
    logic s;
    void'($urandom(32'd5150));
    for (int i = 0; i < 12; i++) begin
      bank[i] = 16'($urandom);
      expv[i] = bank[i];
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    check(dout_en == 1'b0, "R1", "reset dout_en", {15'd0, dout_en}, 16'd0);
    check(we == 1'b0 && rd == 1'b0, "R1", "reset strobes", {14'd0, we, rd}, 16'd0);

    // R10 passthrough
    eoc = 1'b1; #1;
    check(eoc_o == 1'b1, "R10", "eoc high", {15'd0, eoc_o}, 16'd1);
    eoc = 1'b0; #1;
    check(eoc_o == 1'b0, "R10", "eoc low", {15'd0, eoc_o}, 16'd0);

    // R1: activity with select high is ignored
    begin
      int w0, r0;
      w0 = we_cnt; r0 = rd_cnt;
      for (int i = 0; i < 24; i++) send_bit((i % 3) != 2, s);
      check(we_cnt == w0 && rd_cnt == r0, "R1", "no access with cs high", 16'(we_cnt - w0 + rd_cnt - r0), 16'd0);
      check(dout_en == 1'b0, "R1", "dout_en with cs high", {15'd0, dout_en}, 16'd0);
    end
    cs_on();
    check(dout_en == 1'b1, "R1", "dout_en with cs low", {15'd0, dout_en}, 16'd1);
    cs_off();

    // R2/R3/R11 directed
    do_write(2, 16'hA5C3, 0);
    do_read(2, 0, "R3");
    do_write(1, 16'hBEEF, 3);
    do_read(1, 7, "R2");
    do_read(7, 1, "R11");
    do_read(10, 2, "R11");
    do_write(0, 16'h1234, 0);
    do_read(0, 0, "R6");
    do_write(20, 16'h5555, 0);
    do_read(20, 0, "R8");
    do_write(5, 16'h0077, 0);
    do_read(5, 0, "R8");
    do_read(6, 0, "R8");

    // R9: abort in data bits, then in command byte
    begin
      int w0;
      w0 = we_cnt;
      cs_on(); frame(0, 1'b0, 3, 16'hFFFF, 10, g); cs_off();
      check(we_cnt == w0, "R9", "abort in data no write", 16'(we_cnt - w0), 16'd0);
      cs_on();
      send_bit(1'b1, s); send_bit(1'b0, s); send_bit(1'b1, s);
      cs_off();
      check(we_cnt == w0, "R9", "abort in command no write", 16'(we_cnt - w0), 16'd0);
      do_read(3, 0, "R9");
    end

    // R4: back-to-back frames under one select
    begin
      int w0;
      w0 = we_cnt;
      cs_on();
      frame(0, 1'b0, 9, 16'h003C, -1, g);
      frame(0, 1'b0, 11, 16'h9A0F, -1, g);
      frame(2, 1'b1, 11, 16'h0, -1, g);
      check(g == 16'h9A0F, "R4", "read after writes in one select", g, 16'h9A0F);
      frame(0, 1'b1, 9, 16'h0, -1, g);
      check(g == 16'h003C, "R4", "8-bit read in one select", g, 16'h003C);
      cs_off();
      check(we_cnt == w0 + 2, "R4", "two strobes in one select", 16'(we_cnt - w0), 16'd2);
      expv[9] = 16'h003C; expv[11] = 16'h9A0F;
    end

    // constrained random mix
    for (int t = 0; t < 60; t++) begin
      int a, lead;
      a = ($urandom % 4 == 0) ? int'($urandom % 32) : int'($urandom % 12);
      lead = int'($urandom % 4);
      if ($urandom % 2) do_write(a, 16'($urandom), lead);
      else do_read(a, lead, "R7");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule